// File: doc/BRIEF.md
# Store-and-Forward CRC Frame Receiver

This block sits behind a link's word deserializer and turns a raw stream of 32-bit words into verified frames. A frame on the input is a start-marker cycle, a run of data words, one check word and an end-marker cycle. The block stores each frame in one half of a two-bank buffer. When the end marker arrives it compares the check word with a CRC-32 it computed over the data words. Only a frame that passes is released. Its data words then come out back to back on the user side, with a valid flag and a last-word flag.

Holding a frame back until it is verified costs one frame of latency. In exchange, no downstream consumer ever sees data that later turns out to be corrupt. A configuration input bypasses the check: frames are then released whether or not they match, and mismatches are still reported. While one bank is replayed, the other bank takes the next frame. A frame that is too long is dropped, and so is a frame that starts while both banks are still occupied; in both cases an overflow pulse is raised.

The write side is a state machine with states W_IDLE (between frames), W_FILL (storing a frame) and W_SKIP (discarding a frame that found no free bank). Its transitions are:
- W_IDLE to W_FILL on a start marker when the next bank is free.
- W_IDLE to W_SKIP on a start marker when that bank is occupied.
- W_FILL to W_IDLE on an end marker.
- W_FILL to W_FILL on a start marker, which restarts the frame.
- W_SKIP to W_IDLE on an end marker.

The read side has states R_IDLE and R_PLAY. It moves from R_IDLE to R_PLAY when the bank it points at holds a committed frame. It moves from R_PLAY back to R_IDLE after the final word of that frame.

Top module: `crc_frame_rx`

## Requirements
- R1: While reset is asserted and in the first cycle after it, out_valid, out_last, crc_err and ovf_err are low.
- R2: No word of a frame appears on out_data before that frame's end marker has been sampled. The released data words appear in arrival order, with out_valid high in consecutive cycles.
- R3: out_last is high exactly with the final released word of each frame and never without out_valid.
- R4: The check is CRC-32 with generator 0x04C11DB7 and initial value 0xFFFFFFFF, with no final inversion. Each data word is fed in from bit 31 down to bit 0. The check word is the last word before the end marker. A frame whose check word matches is released without its check word.
- R5: With crc_bypass low, a frame whose check word does not match is dropped entirely. crc_err is high for exactly one cycle, the cycle after the end marker.
- R6: With crc_bypass high, a mismatching frame is released in full, and crc_err still pulses as in R5.
- R7: A frame with fewer than two words between its markers (no data word) is dropped and pulses crc_err, whatever the value of crc_bypass.
- R8: A cycle with in_valid low inside a frame stores nothing, so the released words carry no gaps.
- R9: A frame holds at most MAX_DATA data words plus the check word. Each word beyond that raises ovf_err for one cycle, in the cycle after that word. Such a frame is dropped without a crc_err pulse.
- R10: A start marker that arrives while the bank it needs is still occupied raises ovf_err for one cycle. That frame is ignored up to and including its end marker.
- R11: A start marker inside a frame abandons the words gathered so far and starts a new frame.
- R12: Input words outside a frame, and an end marker outside a frame, are ignored.

Marker encoding: a cycle with in_valid and in_sof high is a start marker, and a cycle with in_valid and in_eof high is an end marker. The in_data value in a marker cycle is ignored. When both flags are high in the same cycle, the end marker takes precedence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input cycle carries a word or a marker |
| in_data | input | 32 | Incoming word |
| in_sof | input | 1 | Start marker flag |
| in_eof | input | 1 | End marker flag |
| crc_bypass | input | 1 | Release frames regardless of check result |
| out_valid | output | 1 | out_data holds a released word |
| out_data | output | 32 | Released data word |
| out_last | output | 1 | Final word of the released frame |
| crc_err | output | 1 | One-cycle pulse on a failed or missing check |
| ovf_err | output | 1 | One-cycle pulse on length overflow or no free bank |

## Verification
The hardest condition to reach from the ports is a start marker that finds its bank still occupied. The reader always drains faster than the writer can fill a bank, so this case never arises between well-spaced frames. The bench reaches it by sending a maximum-length frame followed at once by a one-word frame. A third frame then starts in the very cycle in which the reader is emitting the first frame's final word. The bench expects the first two frames to be released intact, the third to vanish with a single overflow pulse, and a later frame to pass normally.

// File: rtl/crc_rx_pkg.sv
package crc_rx_pkg;

    localparam logic [31:0] CRC_POLY = 32'h04C1_1DB7;
    localparam logic [31:0] CRC_INIT = 32'hFFFF_FFFF;

    typedef enum logic [1:0] {
        W_IDLE,
        W_FILL,
        W_SKIP
    } wr_state_t;

    typedef enum logic {
        R_IDLE,
        R_PLAY
    } rd_state_t;

    // Advance the CRC register over one word, most significant bit first.
    function automatic logic [31:0] crc32_word(input logic [31:0] c_in,
                                               input logic [31:0] d);
        logic [31:0] c;
        logic        fb;
        c = c_in;
        for (int i = 31; i >= 0; i--) begin
            fb = c[31] ^ d[i];
            c  = {c[30:0], 1'b0};
            if (fb) c = c ^ CRC_POLY;
        end
        return c;
    endfunction

endpackage

// File: rtl/crc_rx_writer.sv
module crc_rx_writer
    import crc_rx_pkg::*;
#(
    parameter int DEPTH = 17
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          in_valid,
    input  logic [31:0]                   in_data,
    input  logic                          in_sof,
    input  logic                          in_eof,
    input  logic                          crc_bypass,
    input  logic                          bank_free,
    output logic                          wr_en,
    output logic [$clog2(DEPTH)-1:0]      wr_idx,
    output logic [31:0]                   wr_word,
    output logic                          commit,
    output logic [$clog2(DEPTH+1)-1:0]    commit_len,
    output logic                          crc_err,
    output logic                          ovf_err
);
    localparam int IW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    wr_state_t     state, state_nx;
    logic [CW-1:0] count;
    logic [31:0]   crc_cur, crc_prev, last_word;
    logic          over;

    logic end_hit, start_hit, word_hit;
    logic full_now, has_data, crc_match;

    assign end_hit   = in_valid && in_eof;
    assign start_hit = in_valid && in_sof && !in_eof;
    assign word_hit  = in_valid && !in_sof && !in_eof;
    assign full_now  = (count == CW'(DEPTH));
    assign has_data  = (count >= CW'(2));
    assign crc_match = (last_word == crc_prev);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= W_IDLE;
        else        state <= state_nx;
    end

    // Next state
    always_comb begin
        state_nx = state;
        unique case (state)
            W_IDLE: if (start_hit) state_nx = bank_free ? W_FILL : W_SKIP;
            W_FILL: if (end_hit)   state_nx = W_IDLE;
            W_SKIP: if (end_hit)   state_nx = W_IDLE;
            default:               state_nx = W_IDLE;
        endcase
    end

    // Bank write port and commit strobe
    always_comb begin
        wr_en      = (state == W_FILL) && word_hit && !full_now;
        wr_idx     = count[IW-1:0];
        wr_word    = in_data;
        commit     = (state == W_FILL) && end_hit && !over && has_data &&
                     (crc_match || crc_bypass);
        commit_len = count - CW'(1);
    end

    // Frame datapath and status pulses
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count     <= '0;
            crc_cur   <= CRC_INIT;
            crc_prev  <= CRC_INIT;
            last_word <= '0;
            over      <= 1'b0;
            crc_err   <= 1'b0;
            ovf_err   <= 1'b0;
        end else begin
            crc_err <= (state == W_FILL) && end_hit && !over &&
                       (!has_data || !crc_match);
            ovf_err <= ((state == W_IDLE) && start_hit && !bank_free) ||
                       ((state == W_FILL) && word_hit && full_now);
            if (start_hit && (state != W_SKIP)) begin
                count    <= '0;
                crc_cur  <= CRC_INIT;
                crc_prev <= CRC_INIT;
                over     <= 1'b0;
            end else if ((state == W_FILL) && word_hit) begin
                if (full_now) begin
                    over <= 1'b1;
                end else begin
                    count     <= count + CW'(1);
                    crc_prev  <= crc_cur;
                    crc_cur   <= crc32_word(crc_cur, in_data);
                    last_word <= in_data;
                end
            end
        end
    end

endmodule

// File: rtl/crc_rx_banks.sv
module crc_rx_banks #(
    parameter int DEPTH = 17
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [$clog2(DEPTH)-1:0]      wr_idx,
    input  logic [31:0]                   wr_word,
    input  logic                          commit,
    input  logic [$clog2(DEPTH+1)-1:0]    commit_len,
    input  logic [$clog2(DEPTH)-1:0]      rd_idx,
    input  logic                          release_bank,
    output logic                          wr_free,
    output logic                          rd_avail,
    output logic [$clog2(DEPTH+1)-1:0]    rd_len,
    output logic [31:0]                   rd_word
);
    localparam int CW = $clog2(DEPTH + 1);
    localparam int NB = 2;

    logic [31:0]   mem [NB][DEPTH];
    logic [CW-1:0] len [NB];
    logic [NB-1:0] full;
    logic          wr_sel, rd_sel;

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_sel][wr_idx] <= wr_word;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            full   <= '0;
            wr_sel <= 1'b0;
            rd_sel <= 1'b0;
            for (int b = 0; b < NB; b++) len[b] <= '0;
        end else begin
            if (commit) begin
                full[wr_sel] <= 1'b1;
                len[wr_sel]  <= commit_len;
                wr_sel       <= ~wr_sel;
            end
            if (release_bank) begin
                full[rd_sel] <= 1'b0;
                rd_sel       <= ~rd_sel;
            end
        end
    end

    assign wr_free  = !full[wr_sel];
    assign rd_avail = full[rd_sel];
    assign rd_len   = len[rd_sel];
    assign rd_word  = mem[rd_sel][rd_idx];

endmodule

// File: rtl/crc_rx_reader.sv
module crc_rx_reader
    import crc_rx_pkg::*;
#(
    parameter int DEPTH = 17
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          rd_avail,
    input  logic [$clog2(DEPTH+1)-1:0]    rd_len,
    input  logic [31:0]                   rd_word,
    output logic [$clog2(DEPTH)-1:0]      rd_idx,
    output logic                          release_bank,
    output logic                          out_valid,
    output logic [31:0]                   out_data,
    output logic                          out_last
);
    localparam int IW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    rd_state_t state, state_nx;
    logic      at_end;

    assign at_end       = ((CW'(rd_idx) + CW'(1)) == rd_len);
    assign release_bank = (state == R_PLAY) && at_end;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= R_IDLE;
        else        state <= state_nx;
    end

    // Next state
    always_comb begin
        state_nx = state;
        unique case (state)
            R_IDLE: if (rd_avail) state_nx = R_PLAY;
            R_PLAY: if (at_end)   state_nx = R_IDLE;
            default:              state_nx = R_IDLE;
        endcase
    end

    // Registered user outputs and replay index
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_idx    <= '0;
            out_valid <= 1'b0;
            out_data  <= '0;
            out_last  <= 1'b0;
        end else begin
            out_valid <= (state == R_PLAY);
            out_data  <= rd_word;
            out_last  <= (state == R_PLAY) && at_end;
            rd_idx    <= ((state == R_PLAY) && !at_end) ? rd_idx + IW'(1) : '0;
        end
    end

endmodule

// File: rtl/crc_frame_rx.sv
module crc_frame_rx #(
    parameter int MAX_DATA = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_valid,
    input  logic [31:0] in_data,
    input  logic        in_sof,
    input  logic        in_eof,
    input  logic        crc_bypass,
    output logic        out_valid,
    output logic [31:0] out_data,
    output logic        out_last,
    output logic        crc_err,
    output logic        ovf_err
);
    localparam int DEPTH = MAX_DATA + 1;
    localparam int IW    = $clog2(DEPTH);
    localparam int CW    = $clog2(DEPTH + 1);

    logic          wr_en, commit, release_bank, wr_free, rd_avail;
    logic [IW-1:0] wr_idx, rd_idx;
    logic [CW-1:0] commit_len, rd_len;
    logic [31:0]   wr_word, rd_word;

    crc_rx_writer #(.DEPTH(DEPTH)) u_writer (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_data    (in_data),
        .in_sof     (in_sof),
        .in_eof     (in_eof),
        .crc_bypass (crc_bypass),
        .bank_free  (wr_free),
        .wr_en      (wr_en),
        .wr_idx     (wr_idx),
        .wr_word    (wr_word),
        .commit     (commit),
        .commit_len (commit_len),
        .crc_err    (crc_err),
        .ovf_err    (ovf_err)
    );

    crc_rx_banks #(.DEPTH(DEPTH)) u_banks (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (wr_en),
        .wr_idx       (wr_idx),
        .wr_word      (wr_word),
        .commit       (commit),
        .commit_len   (commit_len),
        .rd_idx       (rd_idx),
        .release_bank (release_bank),
        .wr_free      (wr_free),
        .rd_avail     (rd_avail),
        .rd_len       (rd_len),
        .rd_word      (rd_word)
    );

    crc_rx_reader #(.DEPTH(DEPTH)) u_reader (
        .clk          (clk),
        .rst_n        (rst_n),
        .rd_avail     (rd_avail),
        .rd_len       (rd_len),
        .rd_word      (rd_word),
        .rd_idx       (rd_idx),
        .release_bank (release_bank),
        .out_valid    (out_valid),
        .out_data     (out_data),
        .out_last     (out_last)
    );

endmodule

// File: rtl/crc_rx_checker.sv
module crc_rx_checker #(
    parameter int MAX_DATA = 16
) (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic [31:0] in_data,
    input logic        in_sof,
    input logic        in_eof,
    input logic        crc_bypass,
    input logic        out_valid,
    input logic [31:0] out_data,
    input logic        out_last,
    input logic        crc_err,
    input logic        ovf_err
);
    // Words already emitted in the current released frame
    logic [15:0] run;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 run <= '0;
        else if (out_valid && !out_last) run <= run + 16'd1;
        else                        run <= '0;
    end

    // R3: last flag only with a valid word
    a_r3_last_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |-> out_valid);

    // R2: released words of one frame are contiguous
    a_r2_contiguous: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_last) |=> out_valid);

    // R9: a released frame never exceeds the data capacity
    a_r9_len_bound: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (run < 16'(MAX_DATA)));

    // R5: crc error follows an end marker and lasts one cycle
    a_r5_crc_after_end: assert property (@(posedge clk) disable iff (!rst_n)
        crc_err |-> $past(in_valid && in_eof));

    a_r5_crc_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        crc_err |=> !crc_err);

    // R10: overflow only follows an input cycle
    a_r10_ovf_after_input: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_err |-> $past(in_valid));

endmodule

bind crc_frame_rx crc_rx_checker #(.MAX_DATA(MAX_DATA)) u_chk (.*);

// File: tb/tb_crc_frame_rx.sv
module tb_crc_frame_rx;
    localparam int MAXD = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0, crc_bypass = 1'b0;
    logic [31:0] in_data = '0;
    logic        out_valid, out_last, crc_err, ovf_err;
    logic [31:0] out_data;

    always #4 clk = ~clk;

    crc_frame_rx #(.MAX_DATA(MAXD)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_sof(in_sof), .in_eof(in_eof), .crc_bypass(crc_bypass),
        .out_valid(out_valid), .out_data(out_data), .out_last(out_last),
        .crc_err(crc_err), .ovf_err(ovf_err)
    );

    int total = 0, failed = 0;
    int crc_seen = 0, ovf_seen = 0, early = 0;
    int crc_exp = 0, ovf_exp = 0;
    bit in_frame = 1'b0;
    bit done = 1'b0;
    logic [32:0] got_q[$];
    logic [32:0] exp_q[$];
    int fno = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (out_valid) begin
                got_q.push_back({out_last, out_data});
                if (in_frame) early++;
            end
            if (crc_err) crc_seen++;
            if (ovf_err) ovf_seen++;
        end
    end

    function automatic logic [31:0] ref_crc(input logic [31:0] w[$]);
        logic [31:0] c = 32'hFFFF_FFFF;
        foreach (w[k]) begin
            for (int b = 31; b >= 0; b--)
                c = (c << 1) ^ ({32{c[31] ^ w[k][b]}} & 32'h04C1_1DB7);
        end
        return c;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        total++;
        if (!ok) begin
            failed++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic put(input bit v, input bit s, input bit e, input logic [31:0] d);
        @(posedge clk); #1;
        in_valid = v; in_sof = s; in_eof = e; in_data = d;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) put(0, 0, 0, 32'h0);
    endtask

    function automatic logic [31:0] mkword(input int f, input int i);
        return {8'(f), 8'(i), 8'h5A, 8'(f * 7 + i)} ^ 32'h8000_0001;
    endfunction

    // Send one frame of L data words; fwd says whether it should be released.
    task automatic send(input int L, input bit good, input bit gaps, input bit fwd);
        logic [31:0] w[$];
        logic [31:0] c;
        fno++;
        for (int i = 0; i < L; i++) w.push_back(mkword(fno, i));
        c = ref_crc(w) ^ (good ? 32'h0 : 32'h0000_0100);
        put(1, 1, 0, 32'hDEAD_0000);
        for (int i = 0; i < L; i++) begin
            put(1, 0, 0, w[i]);
            if (gaps && (i % 2 == 0)) put(0, 0, 0, 32'hFFFF_FFFF);
        end
        put(1, 0, 0, c);
        put(1, 0, 1, 32'hBEEF_0000);
        if (fwd) for (int i = 0; i < L; i++) exp_q.push_back({i == L - 1, w[i]});
    endtask

    task automatic clear();
        got_q.delete(); exp_q.delete();
        crc_seen = 0; ovf_seen = 0; early = 0; crc_exp = 0; ovf_exp = 0;
    endtask

    task automatic verify(input string tag, input string dtag);
        int dmis = 0, lmis = 0;
        idle(2 * MAXD + 8);
        chk(got_q.size() == exp_q.size(), dtag, "released word count", got_q.size(), exp_q.size());
        if (got_q.size() == exp_q.size()) begin
            foreach (exp_q[k]) begin
                if (got_q[k][31:0] != exp_q[k][31:0]) dmis++;
                if (got_q[k][32] != exp_q[k][32]) lmis++;
            end
        end
        chk(dmis == 0, dtag, "data mismatches", dmis, 0);
        chk(lmis == 0, "R3", "last flag mismatches", lmis, 0);
        chk(crc_seen == crc_exp, tag, "crc_err pulses", crc_seen, crc_exp);
        chk(ovf_seen == ovf_exp, tag, "ovf_err pulses", ovf_seen, ovf_exp);
        clear();
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            failed++; total++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", total - failed, total);
            $finish;
        end
    end

    initial begin
        string tag;
        bit fwd, bad_len;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(!out_valid && !out_last && !crc_err && !ovf_err, "R1", "outputs in reset",
            {out_valid, out_last, crc_err, ovf_err}, 0);
        @(posedge clk); #1 rst_n = 1'b1;
        @(negedge clk);
        chk(!out_valid && !out_last && !crc_err && !ovf_err, "R1", "outputs after reset",
            {out_valid, out_last, crc_err, ovf_err}, 0);

        // Sweep: bypass x check-word correctness x length 0..MAXD+1
        for (int bp = 0; bp < 2; bp++) begin
            for (int g = 0; g < 2; g++) begin
                for (int L = 0; L <= MAXD + 1; L++) begin
                    crc_bypass = bp[0];
                    bad_len = (L > MAXD);
                    fwd = !bad_len && (L >= 1) && (g == 1 || bp == 1);
                    crc_exp = (!bad_len && (L == 0 || g == 0)) ? 1 : 0;
                    ovf_exp = bad_len ? (L - MAXD) : 0;
                    if (bad_len)      tag = "R9";
                    else if (L == 0)  tag = "R7";
                    else if (g == 0)  tag = bp ? "R6" : "R5";
                    else              tag = "R4";
                    in_frame = 1'b1;
                    send(L, g[0], ((L + bp) % 2) == 1, fwd);
                    @(negedge clk);
                    in_frame = 1'b0;
                    chk(early == 0, "R2", "words before end marker", early, 0);
                    verify(tag, (((L + bp) % 2) == 1) ? "R8" : "R2");
                end
            end
        end
        crc_bypass = 1'b0;

        // R11: start marker inside a frame restarts it
        begin
            logic [31:0] w[$];
            w.push_back(32'h1234_5678);
            put(1, 1, 0, 0); put(1, 0, 0, 32'hAAAA_0001); put(1, 0, 0, 32'hAAAA_0002);
            put(1, 1, 0, 0); put(1, 0, 0, w[0]); put(1, 0, 0, ref_crc(w)); put(1, 0, 1, 0);
            exp_q.push_back({1'b1, w[0]});
            verify("R11", "R11");
        end

        // R12: words and an end marker outside any frame
        put(1, 0, 0, 32'h0BAD_0001); put(1, 0, 0, 32'h0BAD_0002); put(1, 0, 1, 0);
        verify("R12", "R12");

        // R10: third frame starts while its bank is still being replayed
        send(MAXD, 1'b1, 1'b0, 1'b1);
        send(1, 1'b1, 1'b0, 1'b1);
        send(2, 1'b1, 1'b0, 1'b0);
        ovf_exp = 1;
        verify("R10", "R10");
        send(3, 1'b1, 1'b0, 1'b1);
        verify("R10", "R10");

        done = 1'b1;
        $display("%0d/%0d checks passed", total - failed, total);
        $finish;
    end

endmodule